// File: doc/BRIEF.md
# Luma/Chroma Timing Alignment Delay

This block re-times a luma sample stream and a chroma sample stream that reach it with unequal pipeline delays, so that matching samples leave together. Each stream runs through its own tapped delay line. A multiplexer picks the tap that sets the effective latency of that stream. Luma moves in steps of one clock. Chroma moves in steps of two clocks, because one chroma pixel spans two luma samples.

Both paths share a fixed base latency (`BASE`, 6 clocks by default), so a stream can be moved earlier as well as later: an earlier shift picks a tap below the base and a later shift picks a tap above it. A valid flag travels with the luma path.

The latencies come from one of two sources. In manual mode they come from a 2-bit luma code and a 3-bit chroma code. In automatic mode they come from a per-format setting chosen by a 2-bit input format code, and the manual codes are ignored.

Top module: `lc_align`

## Requirements
- R1: In manual mode (`auto_en`=0) the luma latency depends on `luma_code`. Code 2'b00 gives BASE clocks (6), 2'b01 gives BASE+1 (7), 2'b10 gives BASE-2 (4) and 2'b11 gives BASE-1 (5).
- R2: In manual mode with `chroma_code` from 3'b001 to 3'b111, the chroma latency is BASE + 2*(code-4) clocks. Code 3'b100 gives no shift, each unit above it adds 2 clocks and each unit below it removes 2 clocks. Over this range the latency runs from 0 to 12.
- R3: A manual `chroma_code` of 3'b000 would need a negative latency. It saturates to 0, so `chroma_out` equals `chroma_in` in the same cycle.
- R4: In automatic mode the settings follow `fmt`:
  - 0 (composite) and the unused code 3 use luma 2'b00 and chroma 3'b011, for latencies of 6 and 4.
  - 1 (Y/C) uses luma 2'b01 and chroma 3'b101, for latencies of 7 and 8.
  - 2 (component) uses luma 2'b01 and chroma 3'b110, for latencies of 7 and 10.
- R5: In automatic mode, changes on `luma_code` and `chroma_code` have no effect on any output.
- R6: `vld_out` is `vld_in` delayed by the current luma latency.
- R7: A change of code, mode or format moves the tap multiplexer in the same cycle. The output sample in that cycle is already the one the new latency selects from the continuous input history.
- R8: Reset clears every delay-line stage. After reset, `vld_out` stays 0 and the outputs read zero until the first valid samples reach the selected taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (one luma sample per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_in | input | DW | Incoming luma sample |
| chroma_in | input | DW | Incoming chroma sample |
| vld_in | input | 1 | Sample valid, travels with luma |
| auto_en | input | 1 | 1 selects format-based settings, 0 selects the manual codes |
| fmt | input | 2 | Input format: 0 composite, 1 Y/C, 2 component |
| luma_code | input | 2 | Manual luma shift code |
| chroma_code | input | 3 | Manual chroma shift code, centred on 3'b100 |
| luma_out | output | DW | Aligned luma |
| chroma_out | output | DW | Aligned chroma |
| vld_out | output | 1 | Valid delayed with the luma path |

## Verification
The bench first drives every manual luma and chroma code pair, then each of the four format codes in automatic mode. Luma and chroma carry two unrelated arithmetic ramps, and the valid flag follows a period-3 pattern. Because each ramp value is unique within the 12-sample window, a wrong tap shows up as a different value: an off-by-one luma tap, an odd chroma step or a swapped path is each detected. The manual codes keep changing throughout the automatic sweep, which separates a correct override from a leak of the manual codes. Every setting change is checked in its first cycle, which tells an immediate tap switch apart from a registered one.

// File: rtl/lc_align.sv
module lc_align #(
  parameter int DW    = 10,
  parameter int BASE  = 6,
  parameter int CSTEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] luma_in,
  input  logic [DW-1:0] chroma_in,
  input  logic          vld_in,
  input  logic          auto_en,
  input  logic [1:0]    fmt,
  input  logic [1:0]    luma_code,
  input  logic [2:0]    chroma_code,
  output logic [DW-1:0] luma_out,
  output logic [DW-1:0] chroma_out,
  output logic          vld_out
);
  localparam int CMID   = 4;
  localparam int LDEPTH = BASE + 1;
  localparam int CDEPTH = BASE + CSTEP * (7 - CMID);

  logic [1:0] auto_l, lsel;
  logic [2:0] auto_c, csel;
  int         ldly, cdly;

  always_comb begin
    case (fmt)
      2'd1:    begin auto_l = 2'b01; auto_c = 3'b101; end
      2'd2:    begin auto_l = 2'b01; auto_c = 3'b110; end
      default: begin auto_l = 2'b00; auto_c = 3'b011; end
    endcase
  end

  assign lsel = auto_en ? auto_l : luma_code;
  assign csel = auto_en ? auto_c : chroma_code;

  always_comb begin
    case (lsel)
      2'b01:   ldly = BASE + 1;
      2'b10:   ldly = BASE - 2;
      2'b11:   ldly = BASE - 1;
      default: ldly = BASE;
    endcase
  end

  always_comb begin
    cdly = BASE + CSTEP * (int'(csel) - CMID);
    if (cdly < 0) cdly = 0;
  end

  logic [DW-1:0] lq [1:LDEPTH];
  logic          vq [1:LDEPTH];
  logic [DW-1:0] cq [1:CDEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= LDEPTH; i++) begin
        lq[i] <= '0;
        vq[i] <= 1'b0;
      end
      for (int i = 1; i <= CDEPTH; i++) cq[i] <= '0;
    end else begin
      lq[1] <= luma_in;
      vq[1] <= vld_in;
      cq[1] <= chroma_in;
      for (int i = 2; i <= LDEPTH; i++) begin
        lq[i] <= lq[i-1];
        vq[i] <= vq[i-1];
      end
      for (int i = 2; i <= CDEPTH; i++) cq[i] <= cq[i-1];
    end
  end

  always_comb begin
    luma_out = luma_in;
    vld_out  = vld_in;
    for (int i = 1; i <= LDEPTH; i++) begin
      if (i == ldly) begin
        luma_out = lq[i];
        vld_out  = vq[i];
      end
    end
  end

  always_comb begin
    chroma_out = chroma_in;
    for (int i = 1; i <= CDEPTH; i++)
      if (i == cdly) chroma_out = cq[i];
  end
endmodule

// File: rtl/lc_align_chk.sv
module lc_align_chk #(
  parameter int DW    = 10,
  parameter int BASE  = 6,
  parameter int CSTEP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] luma_in,
  input logic [DW-1:0] chroma_in,
  input logic          vld_in,
  input logic          auto_en,
  input logic [1:0]    fmt,
  input logic [1:0]    luma_code,
  input logic [2:0]    chroma_code,
  input logic [DW-1:0] luma_out,
  input logic [DW-1:0] chroma_out,
  input logic          vld_out
);
  localparam int HD = BASE + 3 * CSTEP;

  logic [DW-1:0] hl [1:HD];
  logic [DW-1:0] hc [1:HD];
  logic          hv [1:HD];
  logic [7:0]    age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
      for (int i = 1; i <= HD; i++) begin
        hl[i] <= '0; hc[i] <= '0; hv[i] <= 1'b0;
      end
    end else begin
      if (age != 8'hFF) age <= age + 8'd1;
      hl[1] <= luma_in; hc[1] <= chroma_in; hv[1] <= vld_in;
      for (int i = 2; i <= HD; i++) begin
        hl[i] <= hl[i-1]; hc[i] <= hc[i-1]; hv[i] <= hv[i-1];
      end
    end
  end

  function automatic logic [DW-1:0] lpick(int d);
    return (d == 0) ? luma_in : hl[d];
  endfunction
  function automatic logic [DW-1:0] cpick(int d);
    return (d == 0) ? chroma_in : hc[d];
  endfunction
  function automatic logic vpick(int d);
    return (d == 0) ? vld_in : hv[d];
  endfunction

  int man_l, man_c, aut_l, aut_c, cur_l;
  always_comb begin
    man_l = BASE + ((luma_code == 2'b01) ? 1 : (luma_code == 2'b10) ? -2 :
                    (luma_code == 2'b11) ? -1 : 0);
    man_c = BASE - 4 * CSTEP + CSTEP * int'(chroma_code);
    if (man_c < 0) man_c = 0;
    aut_l = (fmt == 2'd1 || fmt == 2'd2) ? BASE + 1 : BASE;
    aut_c = (fmt == 2'd1) ? BASE + CSTEP : (fmt == 2'd2) ? BASE + 2 * CSTEP : BASE - CSTEP;
    cur_l = auto_en ? aut_l : man_l;
  end

  AST_LUMA_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> luma_out == lpick(man_l)); // R1
  AST_CHROMA_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && chroma_code != 3'b000) |-> chroma_out == cpick(man_c)); // R2
  AST_CHROMA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && chroma_code == 3'b000) |-> chroma_out == chroma_in); // R3
  AST_AUTO_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |-> (luma_out == lpick(aut_l) && chroma_out == cpick(aut_c))); // R4
  AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    vld_out == vpick(cur_l)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(age) < BASE - 2) |-> !vld_out); // R8
endmodule

bind lc_align lc_align_chk #(.DW(DW), .BASE(BASE), .CSTEP(CSTEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .luma_in(luma_in), .chroma_in(chroma_in),
  .vld_in(vld_in), .auto_en(auto_en), .fmt(fmt), .luma_code(luma_code),
  .chroma_code(chroma_code), .luma_out(luma_out), .chroma_out(chroma_out),
  .vld_out(vld_out));

// File: tb/lc_align_bench.sv
module lc_align_bench;
  localparam int PERIOD = 10;
  localparam int DW = 10, BASE = 6, CSTEP = 2, HD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] luma_in = '0, chroma_in = '0, luma_out, chroma_out;
  logic vld_in = 1'b0, auto_en = 1'b0, vld_out;
  logic [1:0] fmt = '0, luma_code = '0;
  logic [2:0] chroma_code = '0;

  lc_align #(.DW(DW), .BASE(BASE), .CSTEP(CSTEP)) u_lc_align (
    .clk(clk), .rst_n(rst_n), .luma_in(luma_in), .chroma_in(chroma_in),
    .vld_in(vld_in), .auto_en(auto_en), .fmt(fmt), .luma_code(luma_code),
    .chroma_code(chroma_code), .luma_out(luma_out), .chroma_out(chroma_out),
    .vld_out(vld_out));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, k = 0;
  bit done = 0;
  int hl [0:HD-1];
  int hc [0:HD-1];
  int hv [0:HD-1];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", req, act, exp, k);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int exp_l(logic a, logic [1:0] f, logic [1:0] lc);
    logic [1:0] c = a ? ((f == 2'd1 || f == 2'd2) ? 2'b01 : 2'b00) : lc;
    case (c)
      2'b01: return BASE + 1;
      2'b10: return BASE - 2;
      2'b11: return BASE - 1;
      default: return BASE;
    endcase
  endfunction

  function automatic int exp_c(logic a, logic [1:0] f, logic [2:0] cc);
    int c = a ? ((f == 2'd1) ? 5 : (f == 2'd2) ? 6 : 3) : int'(cc);
    int d = BASE + CSTEP * (c - 4);
    return (d < 0) ? 0 : d;
  endfunction

  task automatic step(logic a, logic [1:0] f, logic [1:0] lc, logic [2:0] cc, bit first);
    int dl, dc;
    string rl, rc;
    @(negedge clk);
    k++;
    for (int i = HD - 1; i >= 1; i--) begin
      hl[i] = hl[i-1]; hc[i] = hc[i-1]; hv[i] = hv[i-1];
    end
    hl[0] = (k * 37 + 5) % 1024;
    hc[0] = (k * 53 + 11) % 1024;
    hv[0] = (k % 3 != 0) ? 1 : 0;
    luma_in = DW'(hl[0]); chroma_in = DW'(hc[0]); vld_in = hv[0][0];
    auto_en = a; fmt = f; luma_code = lc; chroma_code = cc;
    #1;
    dl = exp_l(a, f, lc);
    dc = exp_c(a, f, cc);
    rl = a ? "R4,R5 luma" : "R1 luma";
    rc = a ? "R4,R5 chroma" : (cc == 3'b000 ? "R3 chroma" : "R2 chroma");
    if (first) begin
      rl = {"R7 ", rl};
      rc = {"R7 ", rc};
    end
    check(rl, int'(luma_out), hl[dl]);
    check(rc, int'(chroma_out), hc[dc]);
    check("R6 valid", int'(vld_out), hv[dl]);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < HD; i++) begin
      hl[i] = 0; hc[i] = 0; hv[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 reset luma", int'(luma_out), 0);
    check("R8 reset valid", int'(vld_out), 0);
    check("R8 reset chroma", int'(chroma_out), 0);
    for (int lc = 0; lc < 4; lc++)
      for (int cc = 0; cc < 8; cc++)
        for (int s = 0; s < 14; s++)
          step(1'b0, 2'd0, 2'(lc), 3'(cc), s == 0);
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 16; s++)
        step(1'b1, 2'(f), 2'(s), 3'(s * 3 + f), s == 0);
    step(1'b0, 2'd2, 2'b10, 3'b111, 1'b1);
    step(1'b0, 2'd2, 2'b10, 3'b001, 1'b1);
    finish_run();
  end
endmodule